// File: doc/BRIEF.md
# Accumulator Arithmetic Error Trap Unit

This unit sits beside a DSP datapath that has two 40-bit accumulators. Each cycle in which the datapath writes an accumulator, it passes the unit the exact result of that add or subtract, widened to 41 bits, together with the accumulator's saturation setting. The unit keeps two sticky status bits for each accumulator. One records an overflow beyond the 32-bit range. The other records a catastrophic overflow beyond the full 40-bit range. A later non-overflowing write to the same accumulator clears both bits.

The unit also watches two other events, and neither can be masked. The first is a divide whose first step sees a zero divisor. The second is an accumulator shift whose amount falls outside the legal range. For an out-of-range shift, the unit withholds the write-back enable, so the computed shift result never reaches the accumulator.

Every trapping cause sets a sticky math-error flag. The trap request stays raised while that flag is set. Software may clear the flag, but a clear is refused while an enabled overflow cause is still present.

Top module: `acc_trap_unit`

## Requirements
- R1: When `op_valid_x` is high and `sat_mode_x` is not 2'b01, `ovf_x` is 1 after the next clock edge exactly when the 41-bit result bits [40:31] are not all equal. Otherwise, `ovf_x` is 0 after that edge.
- R2: When `op_valid_x` is high and `sat_mode_x` is 2'b00, `cat_x` is 1 after the next clock edge exactly when result bit 40 differs from bit 39. Otherwise, `cat_x` is 0 after that edge.
- R3: The value of `sat_mode_x` sets which overflows are suppressed:
  - 2'b01 (31-bit saturation) suppresses both overflow kinds.
  - 2'b10 and 2'b11 (39-bit saturation) suppress only the catastrophic kind.
  - 2'b00 suppresses neither.
- R4: An overflow sets `matherr` only when its enable is high:
  - `en_ova` enables it for accumulator A.
  - `en_ovb` enables it for accumulator B.
  - `en_cov` enables it for a catastrophic overflow of either accumulator.
  - A disabled overflow still updates its status bit.
- R5: `div_valid` high with `div_zero` high sets `matherr` at the next edge only when `div_first` is also high. No enable can mask this.
- R6: When `shift_valid` is high, a signed 6-bit `shift_amt` outside -16..+16 sets `matherr` at the next edge. A value of exactly ±16 does not.
- R7: `shift_wr_a` (when `shift_tgt`=0) and `shift_wr_b` (when `shift_tgt`=1) are high in the same cycle only for a valid, in-range shift.
- R8: `matherr` stays set until it is cleared. `trap_req` is high whenever `matherr` is high, or whenever an enabled overflow status bit is set.
- R9: A `clr_matherr` pulse is ignored when the next-state overflow status still holds an enabled cause.
- R10: A `clr_matherr` pulse clears `matherr` when no cause remains. A new trapping event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_a | input | 1 | Accumulator A written this cycle |
| res_a | input | 41 | Exact widened result for A |
| sat_mode_a | input | 2 | Saturation setting for A |
| op_valid_b | input | 1 | Accumulator B written this cycle |
| res_b | input | 41 | Exact widened result for B |
| sat_mode_b | input | 2 | Saturation setting for B |
| en_ova | input | 1 | Trap enable, A overflow |
| en_ovb | input | 1 | Trap enable, B overflow |
| en_cov | input | 1 | Trap enable, catastrophic overflow |
| div_valid | input | 1 | Divide step active |
| div_first | input | 1 | First step of the divide sequence |
| div_zero | input | 1 | Divisor is zero |
| shift_valid | input | 1 | Accumulator shift active |
| shift_amt | input | 6 | Signed shift amount |
| shift_tgt | input | 1 | Shift target, 0=A, 1=B |
| clr_matherr | input | 1 | Software clear request for the flag |
| ovf_a | output | 1 | Sticky 32-bit overflow status, A |
| ovf_b | output | 1 | Sticky 32-bit overflow status, B |
| cat_a | output | 1 | Sticky catastrophic status, A |
| cat_b | output | 1 | Sticky catastrophic status, B |
| matherr | output | 1 | Sticky math-error flag |
| trap_req | output | 1 | Arithmetic trap request |
| shift_wr_a | output | 1 | Shift write-back enable, A |
| shift_wr_b | output | 1 | Shift write-back enable, B |

## Verification
The hardest state to reach is a refused clear. It needs an overflow status bit that is still set, its enable high, and a clear pulse in a cycle that carries no write to that accumulator. The bench builds that state in two steps. First it leaves an overflowed result in accumulator A while every enable is low, which also shows that status updates without trapping. Then it raises the enable, pulses the clear, and only afterwards writes zero to A together with a second clear. Same-cycle races, where a shift trap coincides with a clear, are driven in a single cycle at the clock's falling edge.

// File: rtl/acc_trap_pkg.sv
package acc_trap_pkg;
  localparam int ACC_W    = 40;  // accumulator width
  localparam int LOW_W    = 32;  // range checked for normal overflow
  localparam int SHAMT_W  = 6;   // signed shift amount width
  localparam int SH_LIMIT = 16;  // largest legal shift magnitude

  typedef enum logic [1:0] {
    SAT_OFF  = 2'b00,
    SAT_31   = 2'b01,
    SAT_39   = 2'b10,
    SAT_39_B = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/acc_ovf_monitor.sv
module acc_ovf_monitor #(
  parameter int ACC_W = acc_trap_pkg::ACC_W,
  parameter int LOW_W = acc_trap_pkg::LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [ACC_W:0]   res,
  input  logic [1:0]       sat_mode,
  output logic             ovf_d,
  output logic             cat_d,
  output logic             ovf_q,
  output logic             cat_q
);
  import acc_trap_pkg::*;

  localparam int UP_W = ACC_W - LOW_W + 2;  // bits [ACC_W:LOW_W-1]

  // Result leaves the LOW_W signed range when the top bits disagree.
  function automatic logic beyond_low(input logic [ACC_W:0] r);
    logic [UP_W-1:0] up;
    up = r[ACC_W:LOW_W-1];
    return !((&up) || !(|up));
  endfunction

  // Result leaves the ACC_W signed range.
  function automatic logic beyond_full(input logic [ACC_W:0] r);
    return r[ACC_W] ^ r[ACC_W-1];
  endfunction

  logic sat31, sat_any;
  assign sat31   = (sat_mode_e'(sat_mode) == SAT_31);
  assign sat_any = (sat_mode_e'(sat_mode) != SAT_OFF);

  always_comb begin
    ovf_d = ovf_q;
    cat_d = cat_q;
    if (op_valid) begin
      ovf_d = !sat31   && beyond_low(res);
      cat_d = !sat_any && beyond_full(res);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      cat_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      cat_q <= cat_d;
    end
  end
endmodule

// File: rtl/acc_shift_gate.sv
module acc_shift_gate #(
  parameter int SHAMT_W  = acc_trap_pkg::SHAMT_W,
  parameter int SH_LIMIT = acc_trap_pkg::SH_LIMIT
) (
  input  logic                      shift_valid,
  input  logic signed [SHAMT_W-1:0] shift_amt,
  input  logic                      shift_tgt,
  output logic                      wr_a,
  output logic                      wr_b,
  output logic                      shift_trap
);
  function automatic logic amt_legal(input logic signed [SHAMT_W-1:0] a);
    int v;
    v = int'(a);
    return (v >= -SH_LIMIT) && (v <= SH_LIMIT);
  endfunction

  logic legal;
  assign legal      = amt_legal(shift_amt);
  assign shift_trap = shift_valid && !legal;
  assign wr_a       = shift_valid && legal && !shift_tgt;
  assign wr_b       = shift_valid && legal &&  shift_tgt;
endmodule

// File: rtl/acc_err_flag.sv
module acc_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);
  // A set in the same cycle as a clear wins; a persisting cause re-sets.
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (set_evt)  flag_q <= 1'b1;
    else if (clr_req)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/acc_trap_unit.sv
module acc_trap_unit #(
  parameter int ACC_W    = acc_trap_pkg::ACC_W,
  parameter int LOW_W    = acc_trap_pkg::LOW_W,
  parameter int SHAMT_W  = acc_trap_pkg::SHAMT_W,
  parameter int SH_LIMIT = acc_trap_pkg::SH_LIMIT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid_a,
  input  logic [ACC_W:0]            res_a,
  input  logic [1:0]                sat_mode_a,
  input  logic                      op_valid_b,
  input  logic [ACC_W:0]            res_b,
  input  logic [1:0]                sat_mode_b,
  input  logic                      en_ova,
  input  logic                      en_ovb,
  input  logic                      en_cov,
  input  logic                      div_valid,
  input  logic                      div_first,
  input  logic                      div_zero,
  input  logic                      shift_valid,
  input  logic signed [SHAMT_W-1:0] shift_amt,
  input  logic                      shift_tgt,
  input  logic                      clr_matherr,
  output logic                      ovf_a,
  output logic                      ovf_b,
  output logic                      cat_a,
  output logic                      cat_b,
  output logic                      matherr,
  output logic                      trap_req,
  output logic                      shift_wr_a,
  output logic                      shift_wr_b
);
  localparam int N_ACC = 2;

  logic             op_v   [N_ACC];
  logic [ACC_W:0]   op_res [N_ACC];
  logic [1:0]       op_sat [N_ACC];
  logic [N_ACC-1:0] ovf_d, cat_d, ovf_q, cat_q;

  assign op_v[0]   = op_valid_a;
  assign op_v[1]   = op_valid_b;
  assign op_res[0] = res_a;
  assign op_res[1] = res_b;
  assign op_sat[0] = sat_mode_a;
  assign op_sat[1] = sat_mode_b;

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    acc_ovf_monitor #(.ACC_W(ACC_W), .LOW_W(LOW_W)) i_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_v[g]),
      .res      (op_res[g]),
      .sat_mode (op_sat[g]),
      .ovf_d    (ovf_d[g]),
      .cat_d    (cat_d[g]),
      .ovf_q    (ovf_q[g]),
      .cat_q    (cat_q[g])
    );
  end

  // Named internal events, observed by the checker.
  logic shift_trap, div_trap, cause_next, cause_now, set_evt;

  acc_shift_gate #(.SHAMT_W(SHAMT_W), .SH_LIMIT(SH_LIMIT)) i_shift (
    .shift_valid (shift_valid),
    .shift_amt   (shift_amt),
    .shift_tgt   (shift_tgt),
    .wr_a        (shift_wr_a),
    .wr_b        (shift_wr_b),
    .shift_trap  (shift_trap)
  );

  assign div_trap   = div_valid && div_first && div_zero;
  assign cause_next = (en_ova && ovf_d[0]) || (en_ovb && ovf_d[1]) ||
                      (en_cov && (|cat_d));
  assign cause_now  = (en_ova && ovf_q[0]) || (en_ovb && ovf_q[1]) ||
                      (en_cov && (|cat_q));
  assign set_evt    = cause_next || div_trap || shift_trap;

  acc_err_flag i_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_req (clr_matherr),
    .flag_q  (matherr)
  );

  assign trap_req = matherr || cause_now;
  assign ovf_a    = ovf_q[0];
  assign ovf_b    = ovf_q[1];
  assign cat_a    = cat_q[0];
  assign cat_b    = cat_q[1];
endmodule

// File: rtl/acc_trap_checker.sv
module acc_trap_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid_a,
  input logic              op_valid_b,
  input logic [1:0]        sat_mode_a,
  input logic [1:0]        sat_mode_b,
  input logic              div_valid,
  input logic              div_first,
  input logic              div_zero,
  input logic              shift_valid,
  input logic signed [5:0] shift_amt,
  input logic              clr_matherr,
  input logic              cause_now,
  input logic              ovf_a,
  input logic              cat_b,
  input logic              matherr,
  input logic              trap_req,
  input logic              shift_wr_a,
  input logic              shift_wr_b
);
  a_r1_sat31_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_a && sat_mode_a == 2'b01 |=> !ovf_a);

  a_r3_sat_no_cat: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_b && sat_mode_b != 2'b00 |=> !cat_b);

  a_r5_div_trap: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid && div_first && div_zero |=> matherr);

  a_r7_no_wb_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    shift_valid && (shift_amt > 6'sd16 || shift_amt < -6'sd16)
      |-> !shift_wr_a && !shift_wr_b);

  a_r8_req_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
    matherr |-> trap_req);

  a_r9_clear_refused: assert property (@(posedge clk) disable iff (!rst_n)
    clr_matherr && cause_now && !op_valid_a && !op_valid_b |=> matherr);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    matherr && !clr_matherr |=> matherr);
endmodule

bind acc_trap_unit acc_trap_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid_a  (op_valid_a),
  .op_valid_b  (op_valid_b),
  .sat_mode_a  (sat_mode_a),
  .sat_mode_b  (sat_mode_b),
  .div_valid   (div_valid),
  .div_first   (div_first),
  .div_zero    (div_zero),
  .shift_valid (shift_valid),
  .shift_amt   (shift_amt),
  .clr_matherr (clr_matherr),
  .cause_now   (cause_now),
  .ovf_a       (ovf_a),
  .cat_b       (cat_b),
  .matherr     (matherr),
  .trap_req    (trap_req),
  .shift_wr_a  (shift_wr_a),
  .shift_wr_b  (shift_wr_b)
);

// File: tb/test_acc_trap_unit.sv
module test_acc_trap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 9;

  typedef struct packed {
    logic        acc;   // 0=A, 1=B
    logic [1:0]  sat;
    logic [40:0] res;
    logic        ovf;   // expected normal overflow status
    logic        cat;   // expected catastrophic status
  } vec_t;

  localparam vec_t VEC [N_VEC] = '{
    '{1'b0, 2'd0, 41'h000_7FFF_FFFF, 1'b0, 1'b0},
    '{1'b0, 2'd0, 41'h000_8000_0000, 1'b1, 1'b0},
    '{1'b0, 2'd0, 41'h080_0000_0000, 1'b1, 1'b1},
    '{1'b0, 2'd1, 41'h080_0000_0000, 1'b0, 1'b0},
    '{1'b1, 2'd0, 41'h1FF_8000_0000, 1'b0, 1'b0},
    '{1'b1, 2'd0, 41'h1FF_7FFF_FFFF, 1'b1, 1'b0},
    '{1'b1, 2'd3, 41'h100_0000_0000, 1'b1, 1'b0},
    '{1'b1, 2'd0, 41'h000_0000_0000, 1'b0, 1'b0},
    '{1'b0, 2'd2, 41'h080_0000_0000, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid_a, op_valid_b;
  logic [40:0] res_a, res_b;
  logic [1:0] sat_mode_a, sat_mode_b;
  logic en_ova, en_ovb, en_cov;
  logic div_valid, div_first, div_zero;
  logic shift_valid, shift_tgt, clr_matherr;
  logic signed [5:0] shift_amt;
  logic ovf_a, ovf_b, cat_a, cat_b, matherr, trap_req, shift_wr_a, shift_wr_b;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_trap_unit i_acc_trap_unit (
    .clk(clk), .rst_n(rst_n),
    .op_valid_a(op_valid_a), .res_a(res_a), .sat_mode_a(sat_mode_a),
    .op_valid_b(op_valid_b), .res_b(res_b), .sat_mode_b(sat_mode_b),
    .en_ova(en_ova), .en_ovb(en_ovb), .en_cov(en_cov),
    .div_valid(div_valid), .div_first(div_first), .div_zero(div_zero),
    .shift_valid(shift_valid), .shift_amt(shift_amt), .shift_tgt(shift_tgt),
    .clr_matherr(clr_matherr),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .cat_a(cat_a), .cat_b(cat_b),
    .matherr(matherr), .trap_req(trap_req),
    .shift_wr_a(shift_wr_a), .shift_wr_b(shift_wr_b)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid_a = 0; op_valid_b = 0; res_a = '0; res_b = '0;
    sat_mode_a = 0; sat_mode_b = 0;
    div_valid = 0; div_first = 0; div_zero = 0;
    shift_valid = 0; shift_amt = '0; shift_tgt = 0; clr_matherr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; en_ova = 0; en_ovb = 0; en_cov = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    check("R8 reset matherr", matherr, 1'b0);
    check("R8 reset trap_req", trap_req, 1'b0);
    check("R1 reset ovf_a", ovf_a, 1'b0);
    check("R2 reset cat_b", cat_b, 1'b0);

    // R1/R2/R3 table, enables all low
    for (int i = 0; i < N_VEC; i++) begin
      idle();
      if (VEC[i].acc == 1'b0) begin
        op_valid_a = 1; res_a = VEC[i].res; sat_mode_a = VEC[i].sat;
      end else begin
        op_valid_b = 1; res_b = VEC[i].res; sat_mode_b = VEC[i].sat;
      end
      @(negedge clk);
      idle();
      check("R1 R3 table ovf", VEC[i].acc ? ovf_b : ovf_a, VEC[i].ovf);
      check("R2 R3 table cat", VEC[i].acc ? cat_b : cat_a, VEC[i].cat);
    end

    // R4: A overflowed with enables off -> no trap
    check("R4 disabled ovf no matherr", matherr, 1'b0);
    check("R4 disabled ovf no trap_req", trap_req, 1'b0);
    en_ova = 1;
    #1 check("R8 enabled status raises trap_req", trap_req, 1'b1);
    @(negedge clk);
    check("R4 enabled ovf sets matherr", matherr, 1'b1);

    // R9: clear refused while A overflow persists
    clr_matherr = 1;
    @(negedge clk);
    clr_matherr = 0;
    check("R9 clear refused", matherr, 1'b1);

    // R10: write zero to A together with a clear
    op_valid_a = 1; res_a = '0; clr_matherr = 1;
    @(negedge clk);
    idle();
    check("R1 ovf_a cleared by clean op", ovf_a, 1'b0);
    check("R10 clear accepted", matherr, 1'b0);
    check("R10 trap_req dropped", trap_req, 1'b0);
    en_ova = 0;

    // R5: divide by zero only on the first step
    div_valid = 1; div_zero = 1; div_first = 0;
    @(negedge clk);
    check("R5 later step ignored", matherr, 1'b0);
    div_first = 1;
    @(negedge clk);
    idle();
    check("R5 first step traps", matherr, 1'b1);
    check("R8 trap_req with flag", trap_req, 1'b1);
    @(negedge clk);
    check("R8 flag sticky", matherr, 1'b1);
    clr_matherr = 1;
    @(negedge clk);
    idle();
    check("R10 clear after div", matherr, 1'b0);

    // R6/R7: shift range
    shift_valid = 1; shift_amt = 6'sd16; shift_tgt = 0;
    #1 check("R7 +16 writes A", shift_wr_a, 1'b1);
    check("R7 +16 not B", shift_wr_b, 1'b0);
    @(negedge clk);
    check("R6 +16 no trap", matherr, 1'b0);
    shift_amt = -6'sd16; shift_tgt = 1;
    #1 check("R7 -16 writes B", shift_wr_b, 1'b1);
    @(negedge clk);
    check("R6 -16 no trap", matherr, 1'b0);
    shift_amt = 6'sd17; shift_tgt = 0;
    #1 check("R7 +17 blocked", shift_wr_a, 1'b0);
    @(negedge clk);
    idle();
    check("R6 +17 traps", matherr, 1'b1);
    clr_matherr = 1;
    @(negedge clk);
    clr_matherr = 0;
    check("R10 clear after shift", matherr, 1'b0);
    shift_valid = 1; shift_amt = -6'sd17; shift_tgt = 1;
    #1 check("R7 -17 blocked", shift_wr_b, 1'b0);
    @(negedge clk);
    idle();
    check("R6 -17 traps", matherr, 1'b1);
    check("R8 trap_req enables low", trap_req, 1'b1);
    // R10: event in same cycle as clear wins
    clr_matherr = 1; shift_valid = 1; shift_amt = 6'sd20;
    @(negedge clk);
    idle();
    check("R10 event wins over clear", matherr, 1'b1);
    clr_matherr = 1;
    @(negedge clk);
    idle();
    check("R10 clear accepted", matherr, 1'b0);

    // R4 catastrophic enable, B overflow enable
    en_cov = 1;
    op_valid_b = 1; res_b = 41'h100_0000_0000; sat_mode_b = 2'd0;
    @(negedge clk);
    idle();
    check("R2 cat_b set", cat_b, 1'b1);
    check("R4 en_cov traps", matherr, 1'b1);
    en_cov = 0;
    op_valid_b = 1; res_b = '0; clr_matherr = 1;
    @(negedge clk);
    idle();
    check("R10 cleared after cat gone", matherr, 1'b0);
    en_ovb = 1;
    op_valid_b = 1; res_b = 41'h1FF_7FFF_FFFF; sat_mode_b = 2'd1;
    @(negedge clk);
    idle();
    check("R3 sat31 suppresses ovf_b", ovf_b, 1'b0);
    check("R4 suppressed ovf no trap", matherr, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule